// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block holds the status byte of a byte-addressed 128K x 8 serial memory and decides whether each write-type request may proceed. It receives instruction strobes that an upstream shifter has already decoded. These are set-enable, clear-enable, status write with its data byte, and memory write with a 17-bit address. It also receives the active-low protect pin and a completion pulse from the programming timer. It answers every status or memory write with a one-cycle accept or reject flag, and it shows a busy bit while a granted write cycle runs.

A status write may program a sticky write-disable bit and a two-bit protected-region code. A status write can go ahead only if three things allow it together: the enable latch, the sticky disable bit and the protect pin. Newly written protection bits stay pending until the write cycle finishes, so the protection that applies during the cycle is the one in force when it started. Memory writes that fall inside the protected region are refused.

Top module: `memwp_guard`

## Requirements
- R1: The status byte is {disable bit, 0, 0, 0, region code[1:0], enable latch, busy}, with the disable bit in bit 7, the region code in bits 3:2, the enable latch in bit 1 and busy in bit 0. Reset sets the byte to 0x00 and both flags to 0.
- R2: When the block is idle, a set-enable strobe sets bit 1 and a clear-enable strobe clears it. The new value is visible in the cycle after the strobe.
- R3: A status write or memory write is rejected when the enable latch is clear. A rejected request leaves the enable latch as it was.
- R4: When the disable bit is 0, a status write with the latch set is accepted at either protect-pin level.
- R5: When the disable bit is 1 and the protect pin is high, a status write with the latch set is accepted.
- R6: When the disable bit is 1 and the protect pin is low, every status write is rejected. In that case bits 7, 3 and 2 stay unchanged and the latch stays set.
- R7: An accepted status write stores data bits 7, 3 and 2 and ignores the other data bits. The old bits 7, 3 and 2 are shown until the completion pulse, and the new values appear in the cycle after it.
- R8: A memory write is rejected when its address lies in the protected region and accepted otherwise, provided the latch is set and the block is idle. Code 00 protects nothing, 01 protects 0x18000–0x1FFFF, 10 protects 0x10000–0x1FFFF and 11 protects the whole array.
- R9: Busy rises in the cycle after an accept. The cycle after a completion pulse received while busy shows busy and the latch both cleared. A completion pulse received while idle has no effect.
- R10: While busy, every status or memory write is rejected, including one that arrives in the same cycle as the completion pulse. While busy, set-enable and clear-enable strobes are ignored.
- R11: The accept and reject flags are one-cycle pulses in the cycle after a request, and they are never high together. If several strobes arrive in one cycle, only the first one in the order status write, memory write, set-enable, clear-enable is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_wel_i | input | 1 | Set-enable instruction strobe |
| clr_wel_i | input | 1 | Clear-enable instruction strobe |
| stat_wr_i | input | 1 | Status write instruction strobe |
| stat_data_i | input | 8 | Data byte for a status write |
| mem_wr_i | input | 1 | Memory write instruction strobe |
| mem_addr_i | input | 17 | Byte address of the memory write |
| prot_n_i | input | 1 | Active-low write-protect pin |
| cyc_done_i | input | 1 | Completion pulse from the programming timer |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Request granted (one-cycle pulse) |
| reject_o | output | 1 | Request refused (one-cycle pulse) |
| busy_o | output | 1 | Write cycle in progress |

## Verification
A completion pulse and a new write request can arrive in the same cycle. The bench provokes this by raising a status write together with the pulse that ends a running status write cycle. The request must be rejected. The pending protection bits must then appear in the next cycle with busy and the latch cleared. The monitor compares the reject flag and the committed status byte in that one cycle.

// File: rtl/memwp_pkg.sv
package memwp_pkg;

    localparam int unsigned STAT_W = 8;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef enum logic [2:0] {
        REQ_IDLE    = 3'd0,
        REQ_STATUS  = 3'd1,
        REQ_MEMORY  = 3'd2,
        REQ_SET_WEL = 3'd3,
        REQ_CLR_WEL = 3'd4
    } req_e;

    typedef struct packed {
        logic srwd;
        bp_e  bp;
        logic wel;
        logic wip;
        logic pend_srwd;
        bp_e  pend_bp;
        logic pend_sr;
        logic accept;
        logic reject;
    } state_t;

    function automatic logic [STAT_W-1:0] pack_status(input state_t s);
        return {s.srwd, 3'b000, s.bp, s.wel, s.wip};
    endfunction

endpackage

// File: rtl/memwp_region.sv
module memwp_region
    import memwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  bp_e               bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic in_half;
    logic in_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_half    = addr_i[TOP];
            assign in_quarter = &addr_i[TOP -: 2];
        end else begin : g_narrow
            assign in_half    = addr_i[TOP];
            assign in_quarter = addr_i[TOP];
        end
    endgenerate

    always_comb begin
        unique case (bp_i)
            BP_NONE:    hit_o = 1'b0;
            BP_QUARTER: hit_o = in_quarter;
            BP_HALF:    hit_o = in_half;
            BP_ALL:     hit_o = 1'b1;
            default:    hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/memwp_arbiter.sv
module memwp_arbiter
    import memwp_pkg::*;
(
    input  logic stat_wr_i,
    input  logic mem_wr_i,
    input  logic set_wel_i,
    input  logic clr_wel_i,
    output req_e kind_o
);
    always_comb begin
        if (stat_wr_i)      kind_o = REQ_STATUS;
        else if (mem_wr_i)  kind_o = REQ_MEMORY;
        else if (set_wel_i) kind_o = REQ_SET_WEL;
        else if (clr_wel_i) kind_o = REQ_CLR_WEL;
        else                kind_o = REQ_IDLE;
    end
endmodule

// File: rtl/memwp_gate.sv
module memwp_gate
    import memwp_pkg::*;
(
    input  req_e kind_i,
    input  logic srwd_i,
    input  logic prot_n_i,
    input  logic wel_i,
    input  logic wip_i,
    input  logic region_hit_i,
    output logic grant_o,
    output logic hw_locked_o
);
    logic base_ok;

    assign hw_locked_o = srwd_i & ~prot_n_i;
    assign base_ok     = wel_i & ~wip_i;

    always_comb begin
        unique case (kind_i)
            REQ_STATUS: grant_o = base_ok & ~hw_locked_o;
            REQ_MEMORY: grant_o = base_ok & ~region_hit_i;
            default:    grant_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/memwp_guard.sv
module memwp_guard
    import memwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_data_i,
    input  logic              mem_wr_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              prot_n_i,
    input  logic              cyc_done_i,
    output logic [7:0]        status_o,
    output logic              accept_o,
    output logic              reject_o,
    output logic              busy_o
);
    localparam int unsigned SRWD_BIT = 7;
    localparam int unsigned BP_HI    = 3;
    localparam int unsigned BP_LO    = 2;

    state_t st_d;
    state_t st_q;
    req_e   kind;
    logic   region_hit;
    logic   grant;
    logic   hw_locked;
    logic   unused_data;

    assign unused_data = ^{stat_data_i[6:4], stat_data_i[1:0], hw_locked};

    memwp_arbiter u_arb (
        .stat_wr_i (stat_wr_i),
        .mem_wr_i  (mem_wr_i),
        .set_wel_i (set_wel_i),
        .clr_wel_i (clr_wel_i),
        .kind_o    (kind)
    );

    memwp_region #(.ADDR_W(ADDR_W)) u_region (
        .bp_i   (st_q.bp),
        .addr_i (mem_addr_i),
        .hit_o  (region_hit)
    );

    memwp_gate u_gate (
        .kind_i       (kind),
        .srwd_i       (st_q.srwd),
        .prot_n_i     (prot_n_i),
        .wel_i        (st_q.wel),
        .wip_i        (st_q.wip),
        .region_hit_i (region_hit),
        .grant_o      (grant),
        .hw_locked_o  (hw_locked)
    );

    always_comb begin
        st_d        = st_q;
        st_d.accept = 1'b0;
        st_d.reject = 1'b0;

        // completion of a running cycle: commit pending status bits
        if (st_q.wip && cyc_done_i) begin
            st_d.wip     = 1'b0;
            st_d.wel     = 1'b0;
            st_d.pend_sr = 1'b0;
            if (st_q.pend_sr) begin
                st_d.srwd = st_q.pend_srwd;
                st_d.bp   = st_q.pend_bp;
            end
        end

        unique case (kind)
            REQ_STATUS: begin
                if (grant) begin
                    st_d.wip       = 1'b1;
                    st_d.pend_sr   = 1'b1;
                    st_d.pend_srwd = stat_data_i[SRWD_BIT];
                    st_d.pend_bp   = bp_e'(stat_data_i[BP_HI:BP_LO]);
                    st_d.accept    = 1'b1;
                end else begin
                    st_d.reject    = 1'b1;
                end
            end
            REQ_MEMORY: begin
                if (grant) begin
                    st_d.wip     = 1'b1;
                    st_d.pend_sr = 1'b0;
                    st_d.accept  = 1'b1;
                end else begin
                    st_d.reject  = 1'b1;
                end
            end
            REQ_SET_WEL: begin
                if (!st_q.wip) st_d.wel = 1'b1;
            end
            REQ_CLR_WEL: begin
                if (!st_q.wip) st_d.wel = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = pack_status(st_q);
    assign accept_o = st_q.accept;
    assign reject_o = st_q.reject;
    assign busy_o   = st_q.wip;

endmodule

// File: rtl/memwp_guard_chk.sv
module memwp_guard_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_wr_i,
    input logic              mem_wr_i,
    input logic [ADDR_W-1:0] mem_addr_i,
    input logic              prot_n_i,
    input logic              cyc_done_i,
    input logic [7:0]        status_o,
    input logic              accept_o,
    input logic              reject_o,
    input logic              busy_o
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({accept_o, reject_o}) <= 1); // R11

    AST_ACCEPT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> ($past(status_o[1]) && !$past(status_o[0]))); // R3

    AST_HW_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && status_o[7] && !prot_n_i) |=> (reject_o && !accept_o)); // R6

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_wr_i || mem_wr_i) && busy_o) |=> reject_o); // R10

    AST_PROT_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && cyc_done_i) |=> $stable({status_o[7], status_o[3:2]})); // R7

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cyc_done_i) |=> (!status_o[1] && !status_o[0])); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> busy_o); // R9

    AST_QUARTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_i && !stat_wr_i && status_o[3:2] == 2'b01
         && mem_addr_i[ADDR_W-1 -: 2] == 2'b11) |=> reject_o); // R8

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000); // R1
endmodule

bind memwp_guard memwp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr_i  (stat_wr_i),
    .mem_wr_i   (mem_wr_i),
    .mem_addr_i (mem_addr_i),
    .prot_n_i   (prot_n_i),
    .cyc_done_i (cyc_done_i),
    .status_o   (status_o),
    .accept_o   (accept_o),
    .reject_o   (reject_o),
    .busy_o     (busy_o)
);

// File: tb/memwp_guard_test.sv
module memwp_guard_test;

    localparam int unsigned AW = 17;

    typedef struct {
        int         due;
        logic       acc;
        logic       rej;
        logic [7:0] stat;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_wel = 1'b0;
    logic          clr_wel = 1'b0;
    logic          stat_wr = 1'b0;
    logic [7:0]    stat_data = 8'h00;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          prot_n = 1'b1;
    logic          cyc_done = 1'b0;
    logic [7:0]    status;
    logic          accept;
    logic          reject;
    logic          busy;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    memwp_guard #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_wel_i   (set_wel),
        .clr_wel_i   (clr_wel),
        .stat_wr_i   (stat_wr),
        .stat_data_i (stat_data),
        .mem_wr_i    (mem_wr),
        .mem_addr_i  (mem_addr),
        .prot_n_i    (prot_n),
        .cyc_done_i  (cyc_done),
        .status_o    (status),
        .accept_o    (accept),
        .reject_o    (reject),
        .busy_o      (busy)
    );

    // monitor: pops expectations whose cycle has come
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (accept !== e.acc || reject !== e.rej || status !== e.stat
                    || busy !== e.stat[0]) begin
                    fails++;
                    $display("FAIL %s: acc/rej/status got %b/%b/%h expected %b/%b/%h",
                             e.tag, accept, reject, status, e.acc, e.rej, e.stat);
                end
            end
        end
    end

    // driver: one request per cycle, expectation due one cycle later
    // op bits: 0 status write, 1 memory write, 2 set-enable, 3 clear-enable, 4 done
    task automatic op(input logic [4:0] o, input logic [7:0] d, input logic [AW-1:0] a,
                      input logic ea, input logic er, input logic [7:0] es, input string tag);
        exp_t e;
        @(negedge clk);
        stat_wr   = o[0];
        mem_wr    = o[1];
        set_wel   = o[2];
        clr_wel   = o[3];
        cyc_done  = o[4];
        stat_data = d;
        mem_addr  = a;
        e.due  = cyc + 1;
        e.acc  = ea;
        e.rej  = er;
        e.stat = es;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        stat_wr  = 1'b0;
        mem_wr   = 1'b0;
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        cyc_done = 1'b0;
        e.due  = cyc + 1;
        e.acc  = 1'b0;
        e.rej  = 1'b0;
        e.tag  = {tag, " (flags drop)"};
        sb.push_back(e);
    endtask

    localparam logic [4:0] SR = 5'b00001, MW = 5'b00010, EN = 5'b00100,
                           DIS = 5'b01000, DN = 5'b10000, NOP = 5'b00000;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (status !== 8'h00 || accept !== 1'b0 || reject !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: status/acc/rej got %h/%b/%b expected 00/0/0",
                     status, accept, reject);
        end
        rst_n = 1'b1;

        op(SR, 8'h8C, '0, 0, 1, 8'h00, "R3 status write without latch");
        op(MW, 8'h00, '0, 0, 1, 8'h00, "R3 memory write without latch");
        op(EN, 8'h00, '0, 0, 0, 8'h02, "R2 set latch");
        op(DIS, 8'h00, '0, 0, 0, 8'h00, "R2 clear latch");
        op(EN, 8'h00, '0, 0, 0, 8'h02, "R2 set latch again");
        prot_n = 1'b0;
        op(SR, 8'hFF, '0, 1, 0, 8'h03, "R4 R7 accept with pin low, bits pending");
        op(NOP, 8'h00, '0, 0, 0, 8'h03, "R7 bits held while busy");
        op(EN, 8'h00, '0, 0, 0, 8'h03, "R10 set-enable ignored while busy");
        op(DIS, 8'h00, '0, 0, 0, 8'h03, "R10 clear-enable ignored while busy");
        op(MW, 8'h00, '0, 0, 1, 8'h03, "R10 memory write while busy");
        op(SR | DN, 8'h00, '0, 0, 1, 8'h8C, "R10 R9 R7 request with done, commit");
        op(EN, 8'h00, '0, 0, 0, 8'h8E, "R2 latch after commit");
        op(SR, 8'h00, '0, 0, 1, 8'h8E, "R6 locked status write");
        op(MW, 8'h00, 17'h00000, 0, 1, 8'h8E, "R8 whole array protected");
        prot_n = 1'b1;
        op(SR, 8'h04, '0, 1, 0, 8'h8F, "R5 disable bit with pin high");
        op(DN, 8'h00, '0, 0, 0, 8'h04, "R7 R9 commit quarter code");
        op(EN, 8'h00, '0, 0, 0, 8'h06, "R2 set latch");
        op(MW, 8'h00, 17'h18000, 0, 1, 8'h06, "R8 quarter lower bound");
        op(MW, 8'h00, 17'h17FFF, 1, 0, 8'h07, "R8 below quarter");
        op(DN, 8'h00, '0, 0, 0, 8'h04, "R9 memory cycle done");
        op(EN, 8'h00, '0, 0, 0, 8'h06, "R2 set latch");
        prot_n = 1'b0;
        op(SR, 8'h08, '0, 1, 0, 8'h07, "R4 half code with pin low");
        op(DN, 8'h00, '0, 0, 0, 8'h08, "R7 commit half code");
        prot_n = 1'b1;
        op(EN, 8'h00, '0, 0, 0, 8'h0A, "R2 set latch");
        op(MW, 8'h00, 17'h10000, 0, 1, 8'h0A, "R8 half lower bound");
        op(MW, 8'h00, 17'h0FFFF, 1, 0, 8'h0B, "R8 below half");
        op(DN, 8'h00, '0, 0, 0, 8'h08, "R9 done");
        op(EN, 8'h00, '0, 0, 0, 8'h0A, "R2 set latch");
        op(SR, 8'h73, '0, 1, 0, 8'h0B, "R7 clear code, other data bits ignored");
        op(DN, 8'h00, '0, 0, 0, 8'h00, "R7 commit cleared code");
        op(EN, 8'h00, '0, 0, 0, 8'h02, "R2 set latch");
        op(MW, 8'h00, 17'h1FFFF, 1, 0, 8'h03, "R8 no protection top address");
        op(DN, 8'h00, '0, 0, 0, 8'h00, "R9 done");
        op(DN, 8'h00, '0, 0, 0, 8'h00, "R9 done while idle ignored");
        op(EN | DIS, 8'h00, '0, 0, 0, 8'h02, "R11 set-enable wins over clear");
        op(SR | MW, 8'h00, 17'h1FFFF, 1, 0, 8'h03, "R11 status write wins over memory");
        op(DN, 8'h00, '0, 0, 0, 8'h00, "R11 done");
        repeat (3) @(negedge clk);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule